// File: doc/BRIEF.md
# Address Translation Cache with Table Fetch

This block sits between a processor's address path and the memory system. It turns a 32-bit virtual address into a physical address for 4 KB pages. The low 12 bits are the page offset and are passed straight through. Only the upper bits, the virtual page number, are looked up among the cached translations. Any page may sit in any slot, so the lookup compares against every slot at once.

When a lookup hits, the physical address comes back one cycle after the request is taken, and no memory access is made. When a lookup misses, the block makes exactly one read of the translation word from a table in memory. That table starts at a base address supplied as an input. If the word is marked valid, the block stores the translation in a slot and answers. If the word is not marked valid, the block answers with a fault flag instead, and nothing is cached.

The block handles one miss at a time. It stops taking requests until the table read returns. A single-cycle input drops every cached translation at once.

Top module: `xlat_tlb`

## Requirements
- R1: After reset, `req_ready` is high and `rsp_valid` and `pte_req_valid` are low. No slot is valid, so the first lookup of any page misses.
- R2: A successful response gives `rsp_paddr[11:0]` equal to the request's `req_vaddr[11:0]`. Its bits 31:12 equal the physical page number of the translation.
- R3: A request taken while its page is cached gives `rsp_valid` high with `rsp_fault` low in the cycle right after the accepting edge. No table read is issued for it.
- R4: A request taken while its page is not cached gives exactly one table read. `pte_req_valid` is a one-cycle pulse in the cycle after the accepting edge, with `pte_req_addr` equal to `pt_base` plus the virtual page number times 4.
- R5: The table word uses bit 0 as the valid flag and bits 31:12 as the physical page number. For a valid word, the response is given in the cycle after `pte_rsp_valid`, and the page hits on later requests.
- R6: For a table word with bit 0 clear, the response has `rsp_fault` high and `rsp_paddr` zero. No slot is filled, so a repeated request for that page reads the table again.
- R7: From the accepting edge of a miss until its response, `req_ready` is low. Requests presented during that time are not taken and give no response.
- R8: Any set of up to ENTRIES distinct pages can be cached at the same time, whatever their page numbers, and all of them hit afterwards.
- R9: A fill goes to the lowest-numbered free slot if one exists. Otherwise it goes to the slot named by a rotating pointer. That pointer starts at slot 0 after reset, advances by one on every fill, and wraps after slot ENTRIES-1.
- R10: A one-cycle pulse on `inv_all` makes every slot invalid from the next cycle on. Later lookups miss. The rotating pointer is not changed. A fill that coincides with the pulse is dropped.
- R11: `rsp_fault` is never high unless `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Drop every cached translation |
| pt_base | input | 32 | Byte address of the translation table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_paddr | output | 32 | Translated physical address (zero on fault) |
| rsp_fault | output | 1 | Table word was not valid |
| pte_req_valid | output | 1 | Table read request, one-cycle pulse |
| pte_req_addr | output | 32 | Byte address of the table word |
| pte_rsp_valid | input | 1 | Table word returned |
| pte_rsp_data | input | 32 | Returned table word |

## Verification
The hardest case to reach from the ports is the rotating-pointer eviction. It only shows after every slot is full, and which page falls out depends on the whole history of fills since reset. The bench builds the block with four slots so this happens early. It fills all four, then keeps asking for pages that were just evicted. A model of the free-slot-first and rotating-pointer rule, run alongside, predicts for every request whether it hits or misses. Requests sent while a miss is pending, and a clear-all pulse followed by refills, check the busy window and the free-slot choice after a clear.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } walk_state_t;
endpackage

// File: rtl/xlat_tag_array.sv
module xlat_tag_array #(
  parameter int ENTRIES = 256,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inv_all,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic               fill_en,
  input  logic [ENTRIES-1:0] fill_sel,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn,
  output logic               hit,
  output logic [PPN_W-1:0]   hit_ppn,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst || inv_all) vld_q <= '0;
    else if (fill_en)   vld_q <= vld_q | fill_sel;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (fill_en && fill_sel[i]) begin
        tag_q[i] <= fill_vpn;
        ppn_q[i] <= fill_ppn;
      end
    end
    assign match[i] = vld_q[i] && (tag_q[i] == lk_vpn);
  end

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_ppn = hit_ppn | ppn_q[i];
    end
  end

  assign hit       = |match;
  assign valid_vec = vld_q;

  // R8: a page is held in at most one slot
  a_r8_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
  // R10: clear takes effect in one cycle
  a_r10_clear_all: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> (valid_vec == '0));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 256,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               advance,
  output logic [ENTRIES-1:0] victim_oh
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;
  logic [IDX_W-1:0] pick;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_free  = ~&valid_vec;
  assign pick      = any_free ? free_idx : rr_q;
  assign victim_oh = ENTRIES'(1) << pick;

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (advance) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  // R9: a free slot is never passed over for a used one
  a_r9_free_first: assert property (@(posedge clk) disable iff (rst)
    (advance && any_free) |-> ((victim_oh & valid_vec) == '0));
  // R9: exactly one slot is chosen
  a_r9_one_victim: assert property (@(posedge clk) disable iff (rst)
    $countones(victim_oh) == 1);
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int OFFS_W = 12,
  parameter int PTE_W  = 32,
  localparam int VPN_W = VA_W - OFFS_W,
  localparam int PPN_W = PA_W - OFFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv_all,
  input  logic [PA_W-1:0]  pt_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic             pte_req_valid,
  output logic [PA_W-1:0]  pte_req_addr,
  input  logic             pte_rsp_valid,
  input  logic [PTE_W-1:0] pte_rsp_data,
  input  logic             hit,
  input  logic [PPN_W-1:0] hit_ppn,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PPN_W-1:0] fill_ppn
);
  walk_state_t       st_q;
  logic [VA_W-1:0]   pend_q;
  logic              accept;
  logic              pte_ok;
  logic [PPN_W-1:0]  pte_ppn;
  logic [VPN_W-1:0]  req_vpn;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign req_vpn   = req_vaddr[VA_W-1:OFFS_W];
  assign pte_ok    = pte_rsp_data[0];
  assign pte_ppn   = pte_rsp_data[PTE_W-1 -: PPN_W];
  assign fill_en   = (st_q == ST_WAIT) && pte_rsp_valid && pte_ok && !inv_all;
  assign fill_vpn  = pend_q[VA_W-1:OFFS_W];
  assign fill_ppn  = pte_ppn;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      pend_q        <= '0;
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_fault     <= 1'b0;
      pte_req_valid <= 1'b0;
      pte_req_addr  <= '0;
    end else begin
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      pte_req_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (hit) begin
              rsp_valid <= 1'b1;
              rsp_paddr <= {hit_ppn, req_vaddr[OFFS_W-1:0]};
            end else begin
              pend_q        <= req_vaddr;
              pte_req_valid <= 1'b1;
              pte_req_addr  <= pt_base + {{(PA_W-VPN_W-2){1'b0}}, req_vpn, 2'b00};
              st_q          <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (pte_rsp_valid) begin
            st_q      <= ST_IDLE;
            rsp_valid <= 1'b1;
            if (pte_ok) begin
              rsp_paddr <= {pte_ppn, pend_q[OFFS_W-1:0]};
            end else begin
              rsp_paddr <= '0;
              rsp_fault <= 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R11: fault only with a response
  a_r11_fault_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_valid);
  // R6: faulting response carries no address
  a_r6_fault_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_paddr == '0));
  // R4: a table read only follows a taken request
  a_r4_read_after_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(pte_req_valid) |-> $past(req_valid && req_ready));
  // R7: no new request is taken while a table read is pending
  a_r7_busy: assert property (@(posedge clk) disable iff (rst)
    pte_req_valid |-> !req_ready);
  // R3: a hit answers on the next cycle without fault
  a_r3_hit_next: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && hit) |=> (rsp_valid && !rsp_fault && !pte_req_valid));
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int ENTRIES = 256,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFFS_W  = 12,
  parameter int PTE_W   = 32,
  localparam int VPN_W  = VA_W - OFFS_W,
  localparam int PPN_W  = PA_W - OFFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv_all,
  input  logic [PA_W-1:0]  pt_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic             pte_req_valid,
  output logic [PA_W-1:0]  pte_req_addr,
  input  logic             pte_rsp_valid,
  input  logic [PTE_W-1:0] pte_rsp_data
);
  logic               hit;
  logic [PPN_W-1:0]   hit_ppn;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] victim_oh;
  logic               fill_en;
  logic [VPN_W-1:0]   fill_vpn;
  logic [PPN_W-1:0]   fill_ppn;

  xlat_tag_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_array (
    .clk(clk), .rst(rst), .inv_all(inv_all),
    .lk_vpn(req_vaddr[VA_W-1:OFFS_W]),
    .fill_en(fill_en), .fill_sel(victim_oh),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .hit(hit), .hit_ppn(hit_ppn), .valid_vec(valid_vec)
  );

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .valid_vec(valid_vec),
    .advance(fill_en), .victim_oh(victim_oh)
  );

  xlat_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .OFFS_W(OFFS_W), .PTE_W(PTE_W)) u_ctrl (
    .clk(clk), .rst(rst), .inv_all(inv_all), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .pte_req_valid(pte_req_valid), .pte_req_addr(pte_req_addr),
    .pte_rsp_valid(pte_rsp_valid), .pte_rsp_data(pte_rsp_data),
    .hit(hit), .hit_ppn(hit_ppn),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn)
  );

  // R1: no response or table read right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && !pte_req_valid));
endmodule

// File: tb/tb_xlat_tlb.sv
module tb_xlat_tlb;
  localparam int N = 4;
  localparam logic [31:0] BASE = 32'h0008_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inv_all = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        pte_rsp_valid = 1'b0;
  logic [31:0] pte_rsp_data = '0;
  logic        req_ready, rsp_valid, rsp_fault, pte_req_valid;
  logic [31:0] rsp_paddr, pte_req_addr;

  always #10 clk = ~clk;

  xlat_tlb #(.ENTRIES(N)) dut (
    .clk(clk), .rst(rst), .inv_all(inv_all), .pt_base(BASE),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .pte_req_valid(pte_req_valid), .pte_req_addr(pte_req_addr),
    .pte_rsp_valid(pte_rsp_valid), .pte_rsp_data(pte_rsp_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int pte_seen = 0;
  logic [31:0] pte_last_addr = '0;
  bit done = 0;

  typedef struct packed {
    logic [31:0] pa;
    logic        flt;
    logic        miss;
  } exp_t;
  exp_t  q[$];
  string tq[$];

  logic [19:0] m_vpn [N];
  bit          m_v   [N];
  int          m_ptr = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pte_of(input logic [19:0] vpn);
    logic [19:0] ppn;
    ppn = {vpn[9:0], vpn[19:10]} ^ 20'h3C5A1;
    return {ppn, 11'h0, (vpn[3:0] != 4'hF)};
  endfunction

  // memory model for table reads
  always begin
    @(negedge clk);
    if (!rst && pte_req_valid) begin
      logic [31:0] a;
      a = pte_req_addr;
      pte_seen++;
      pte_last_addr = a;
      chk(req_ready == 1'b0, "R7", "ready while read pending", {31'b0, req_ready}, 32'h0);
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b0, "R7", "ready before table word", {31'b0, req_ready}, 32'h0);
      pte_rsp_valid = 1'b1;
      pte_rsp_data  = pte_of(20'((a - BASE) >> 2));
      @(negedge clk);
      pte_rsp_valid = 1'b0;
      pte_rsp_data  = '0;
    end
  end

  // monitor: pops the scoreboard when a response appears
  always @(negedge clk) begin
    if (!rst && rsp_fault && !rsp_valid)
      chk(1'b0, "R11", "fault without valid", 32'h1, 32'h0);
    if (!rst && rsp_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7", "unexpected response", rsp_paddr, 32'h0);
      end else begin
        exp_t e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        chk(rsp_paddr == e.pa, t, "paddr", rsp_paddr, e.pa);
        chk(rsp_fault == e.flt, t, "fault", {31'b0, rsp_fault}, {31'b0, e.flt});
        chk(pte_seen == int'(e.miss), t, "table reads", 32'(pte_seen), {31'b0, e.miss});
        pte_seen = 0;
      end
    end
  end

  task automatic xlate(input logic [31:0] va, input string tag, input bit junk);
    logic [19:0] vpn;
    int hi;
    exp_t e;
    logic [31:0] w;
    vpn = va[31:12];
    hi = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) hi = i;
    e.miss = (hi < 0);
    e.flt = 1'b0;
    if (hi >= 0) begin
      e.pa = {pte_of(vpn)[31:12], va[11:0]};
    end else begin
      w = pte_of(vpn);
      if (w[0]) begin
        int v;
        v = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) v = i;
        if (v < 0) v = m_ptr;
        m_v[v] = 1; m_vpn[v] = vpn;
        m_ptr = (m_ptr + 1) % N;
        e.pa = {w[31:12], va[11:0]};
      end else begin
        e.pa = '0;
        e.flt = 1'b1;
      end
    end
    q.push_back(e);
    tq.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (e.miss) begin
      chk(pte_req_valid == 1'b1, "R4", "table read pulse", {31'b0, pte_req_valid}, 32'h1);
      chk(pte_req_addr == BASE + {10'b0, vpn, 2'b00}, "R4", "table address",
          pte_req_addr, BASE + {10'b0, vpn, 2'b00});
      if (junk) begin
        req_valid = 1'b1;
        req_vaddr = 32'hDEAD_0123;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
      end
    end else begin
      chk(rsp_valid == 1'b1, "R3", "hit latency", {31'b0, rsp_valid}, 32'h1);
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_vpn[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    chk(pte_req_valid == 1'b0, "R1", "pte_req_valid after reset", {31'b0, pte_req_valid}, 32'h0);

    xlate(32'h0001_0123, "R1", 0);
    xlate(32'h0001_0ABC, "R2", 0);
    xlate(32'h0001_0FFF, "R3", 0);
    xlate(32'h0002_F456, "R6", 0);
    xlate(32'h0002_F000, "R6", 0);
    xlate(32'h0001_1000, "R5", 0);
    xlate(32'hFFFF_0777, "R5", 0);
    xlate(32'h7FF0_0321, "R5", 0);
    xlate(32'h0001_1001, "R8", 0);
    xlate(32'hFFFF_0FFF, "R8", 0);
    xlate(32'h7FF0_0000, "R8", 0);
    xlate(32'h0001_0010, "R8", 0);
    xlate(32'h0002_0AAA, "R9", 0);
    xlate(32'h0001_0BBB, "R9", 0);
    xlate(32'h0001_1CCC, "R9", 0);
    xlate(32'hFFFF_0DDD, "R9", 0);
    xlate(32'h0002_0EEE, "R9", 0);
    xlate(32'h0003_0123, "R7", 1);
    xlate(32'h0003_0456, "R7", 0);

    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    xlate(32'h0003_0789, "R10", 0);
    xlate(32'h0002_0111, "R10", 0);
    xlate(32'h0003_0222, "R10", 0);
    xlate(32'h0004_0333, "R9", 0);
    xlate(32'h0005_0444, "R9", 0);
    xlate(32'h0006_0555, "R9", 0);
    xlate(32'h0003_0666, "R9", 0);

    repeat (8) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule